// File: doc/BRIEF.md
# Pruned CIC Decimation Filter

This block is a single-channel cascaded integrator-comb decimator. It accepts 14-bit signed samples qualified by a valid strobe. For every 16 accepted samples it emits one 22-bit signed sample, also qualified by a one-cycle strobe. There are eight integrator stages at the input rate and eight comb stages, each with a differential delay of one, at the output rate.

The internal word is kept at full Hogenauer precision only where it has to be. Each stage drops a parameterised number of low-order bits, and the drop counts never decrease along the chain. At each narrowing point the dropped field is rounded (add half an LSB of the kept field, then discard). A parameter can select plain truncation instead. Before the first integrator the input carries one duplicated sign bit. This guard bit keeps the most negative input code on the exact scaled DC value rather than producing a stray sample.

Integrators wrap modulo their own width. Only the last comb output has to be free of wraparound, and that output is rounded to 22 bits with saturation.

Top module: `cic_pruned_decim`

## Requirements
- R1: A synchronous active-low reset clears every integrator, comb delay, the sample counter and the output register. While reset is held, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` rises for exactly one cycle per 16 accepted samples. It is high in the second cycle after the cycle in which the 16th sample of the group is presented.
- R3: While `in_valid` is low, `in_data` has no effect. The sample is not accumulated and does not advance the group count.
- R4: Output number m (counting from 0) equals the exact response rounded half-up after a right shift of 25 bits, within ±1 LSB. The exact response is the sum over k of h[k]·x[16m+8−k], where h holds the 121 coefficients of ((1−z^-16)/(1−z^-1))^8 and samples before the first are zero.
- R5: When all 121 samples in an output's window equal a constant c, the output is exactly c·128.
- R6: Both full-scale constants give exact outputs with no anomalous sample: −8192 gives −1048576 and +8191 gives +1048448.
- R7: A sweep of constant inputs from −8192 up to +8191 gives settled outputs that rise strictly with the input code.
- R8: `out_data` changes only in a cycle where `out_valid` is high, and keeps its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 14 | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle decimated output strobe |
| out_data | output | 22 | Signed decimated output sample |

## Verification
The assertions assume that reset is held for at least two clock edges before the first sample. They also assume that `in_valid` is a plain per-cycle qualifier with no back-pressure, so a group is complete when the 16th valid is seen. The timing assertions also rely on no reset arriving while an output is in flight.

The stimulus meets these conditions. It holds reset for four cycles at start-up. Before the mid-run reset it idles the input for several cycles, so that any pending output has left the block.

Random gap patterns only toggle `in_valid`. Input codes always stay inside the 14-bit range.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
// Shared types for the pruned CIC decimator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cic_pkg;
    // How dropped low-order bits are removed at a narrowing point.
    typedef enum logic {
        TRIM_ROUND = 1'b0,
        TRIM_TRUNC = 1'b1
    } trim_mode_e;
endpackage

// File: rtl/cic_prune.sv
`timescale 1ns/1ps
// Narrows a word by SHIFT low-order bits, rounding half-up or truncating.
// Assumes modular (wrapping) arithmetic is acceptable for the caller, as
// it is for integrator and comb registers.
module cic_prune
    import cic_pkg::*;
#(
    parameter int         IN_W  = 32,
    parameter int         SHIFT = 0,
    parameter trim_mode_e TRIM  = TRIM_ROUND
) (
    input  logic [IN_W-1:0]       din,
    output logic [IN_W-SHIFT-1:0] dout
);
    if (SHIFT == 0) begin : g_pass
        // No narrowing at this boundary.
        assign dout = din;
    end else begin : g_cut
        localparam logic [IN_W-1:0] HALF =
            (TRIM == TRIM_ROUND) ? ((IN_W)'(1) << (SHIFT - 1)) : '0;
        logic [IN_W-1:0] biased;
        logic            unused_low;
        // Bias by half an LSB of the kept field, then drop the low field.
        assign biased     = din + HALF;
        assign dout       = biased[IN_W-1:SHIFT];
        assign unused_low = ^biased[SHIFT-1:0];
    end
endmodule

// File: rtl/cic_integ.sv
`timescale 1ns/1ps
// One integrator register: accumulates its input when enabled.
// Assumes wraparound modulo 2^W is intended.
module cic_integ #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);
    // Accumulate on each accepted sample; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= acc + din;
    end
endmodule

// File: rtl/cic_comb.sv
`timescale 1ns/1ps
// One comb stage with a differential delay of one decimated sample.
// Assumes en pulses only on decimated cycles; output is combinational.
module cic_comb #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] prev;

    // Difference against the previous decimated input.
    assign dout = din - prev;

    // Remember the current input for the next decimated cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  prev <= '0;
        else if (en) prev <= din;
    end
endmodule

// File: rtl/cic_outround.sv
`timescale 1ns/1ps
// Final narrowing of the comb result to the output width, with saturation.
// Assumes IN_W >= OUT_W and a wrap-free signed input.
module cic_outround
    import cic_pkg::*;
#(
    parameter int         IN_W  = 31,
    parameter int         OUT_W = 22,
    parameter trim_mode_e TRIM  = TRIM_ROUND
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int SHIFT = IN_W - OUT_W;

    if (SHIFT == 0) begin : g_pass
        // Widths already match.
        assign dout = din;
    end else begin : g_cut
        localparam logic signed [IN_W:0] HALF =
            (TRIM == TRIM_ROUND) ? ((IN_W + 1)'(1) <<< (SHIFT - 1)) : '0;
        localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
        localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};
        logic signed [IN_W:0]  wide;
        logic        [OUT_W:0] kept;
        logic                  unused_low;
        // One headroom bit so the rounding increment cannot wrap.
        assign wide       = {din[IN_W-1], din} + HALF;
        assign kept       = wide[IN_W:SHIFT];
        assign unused_low = ^wide[SHIFT-1:0];
        // Clamp when the kept field no longer fits the output width.
        always_comb begin
            if (kept[OUT_W] != kept[OUT_W-1]) dout = kept[OUT_W] ? MIN_V : MAX_V;
            else                              dout = kept[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/cic_pruned_decim.sv
`timescale 1ns/1ps
// Pruned CIC decimator, one channel, fixed rate 2^RATE_LOG2, delay one.
// Integrators run at the input rate on in_valid; the comb chain is a single
// combinational path evaluated on the cycle after each 16th sample.
// Assumes DROP is non-decreasing and DROP[last] leaves the comb output
// at least OUT_W bits wide.
module cic_pruned_decim
    import cic_pkg::*;
#(
    parameter int         IN_W      = 14,
    parameter int         OUT_W     = 22,
    parameter int         STAGES    = 8,
    parameter int         RATE_LOG2 = 4,
    parameter trim_mode_e TRIM      = TRIM_ROUND,
    parameter int         DROP [0:2*STAGES-1] =
        '{0, 0, 0, 0, 2, 4, 6, 8, 9, 10, 11, 12, 13, 14, 15, 16}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int GUARD_W    = IN_W + 1;
    localparam int FULL_W     = GUARD_W + STAGES * RATE_LOG2;
    localparam int COMB_OUT_W = FULL_W - DROP[2*STAGES-1];

    logic [FULL_W-1:0]          x_ext;
    logic [RATE_LOG2-1:0]       phase;
    logic                       dec_q;
    logic signed [OUT_W-1:0]    out_next;

    // Duplicated sign bit, then sign extension to full precision.
    assign x_ext = {{(FULL_W-GUARD_W){in_data[IN_W-1]}}, in_data[IN_W-1], in_data};

    for (genvar k = 0; k < STAGES; k++) begin : g_int
        localparam int WI = FULL_W - DROP[k];
        logic [WI-1:0] feed;
        logic [WI-1:0] acc;
        if (k == 0) begin : g_src
            cic_prune #(.IN_W(FULL_W), .SHIFT(DROP[0]), .TRIM(TRIM)) u_prune (
                .din(x_ext), .dout(feed));
        end else begin : g_src
            cic_prune #(.IN_W(FULL_W - DROP[k-1]), .SHIFT(DROP[k] - DROP[k-1]),
                        .TRIM(TRIM)) u_prune (
                .din(g_int[k-1].acc), .dout(feed));
        end
        cic_integ #(.W(WI)) u_integ (
            .clk(clk), .rst_n(rst_n), .en(in_valid), .din(feed), .acc(acc));
    end

    for (genvar j = 0; j < STAGES; j++) begin : g_cmb
        localparam int WC = FULL_W - DROP[STAGES+j];
        logic [WC-1:0] feed;
        logic [WC-1:0] dout;
        if (j == 0) begin : g_src
            cic_prune #(.IN_W(FULL_W - DROP[STAGES-1]),
                        .SHIFT(DROP[STAGES] - DROP[STAGES-1]), .TRIM(TRIM)) u_prune (
                .din(g_int[STAGES-1].acc), .dout(feed));
        end else begin : g_src
            cic_prune #(.IN_W(FULL_W - DROP[STAGES+j-1]),
                        .SHIFT(DROP[STAGES+j] - DROP[STAGES+j-1]), .TRIM(TRIM)) u_prune (
                .din(g_cmb[j-1].dout), .dout(feed));
        end
        cic_comb #(.W(WC)) u_comb (
            .clk(clk), .rst_n(rst_n), .en(dec_q), .din(feed), .dout(dout));
    end

    cic_outround #(.IN_W(COMB_OUT_W), .OUT_W(OUT_W), .TRIM(TRIM)) u_outround (
        .din(g_cmb[STAGES-1].dout), .dout(out_next));

    // Count accepted samples and flag the cycle after each full group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            dec_q <= 1'b0;
        end else begin
            dec_q <= in_valid && (phase == '1);
            if (in_valid) phase <= phase + 1'b1;
        end
    end

    // Register the decimated result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= dec_q;
            if (dec_q) out_data <= out_next;
        end
    end
endmodule

// File: rtl/cic_pruned_decim_chk.sv
`timescale 1ns/1ps
// Property checker for cic_pruned_decim, attached with bind.
// Assumes reset is held for two or more edges at start and that no reset
// lands while an output is in flight.
module cic_pruned_decim_chk #(
    parameter int RATE_LOG2 = 4,
    parameter int OUT_W     = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);
    logic [RATE_LOG2-1:0] seen;
    logic                 last_flag;

    // Independent count of accepted samples within a group.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen <= '0;
        else if (in_valid) seen <= seen + 1'b1;
    end
    assign last_flag = in_valid && (seen == '1);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        last_flag |-> ##2 out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(last_flag, 2));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind cic_pruned_decim cic_pruned_decim_chk #(
    .RATE_LOG2(RATE_LOG2),
    .OUT_W    (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/cic_pruned_decim_tb.sv
`timescale 1ns/1ps
// Bench: behavioural convolution model, compared every clock.
module cic_pruned_decim_tb;
    localparam int IN_W  = 14;
    localparam int OUT_W = 22;
    localparam int TAPS  = 121;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;

    cic_pruned_decim u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data));

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int     n_checks = 0;
    int     n_fail   = 0;
    longint h [TAPS];
    longint xs [$];
    int     nacc = 0;
    bit     dc_mode = 0;
    int     seg_start = 0;
    int     seg_val = 0;
    int     exp_cyc [$];
    longint exp_val [$];
    bit     exp_exact [$];
    string  exp_tag [$];
    bit     chk_on = 0;
    longint last_out = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void build_taps();
        longint tmp [TAPS];
        int len = 1;
        foreach (h[i]) h[i] = 0;
        h[0] = 1;
        for (int s = 0; s < 8; s++) begin
            foreach (tmp[i]) tmp[i] = 0;
            for (int i = 0; i < len; i++)
                for (int j = 0; j < 16; j++) tmp[i+j] += h[i];
            foreach (h[i]) h[i] = tmp[i];
            len += 15;
        end
    endfunction

    // Record an accepted sample; on every 16th, predict the output.
    task automatic model_push(input int x);
        longint f = 0;
        int     idx;
        bit     ex;
        xs.push_back(x);
        nacc++;
        if (nacc % 16 == 0) begin
            idx = nacc - 8;
            for (int k = 0; k < TAPS; k++)
                if (idx - k >= 0) f += h[k] * xs[idx-k];
            ex = dc_mode && (idx - (TAPS - 1) >= seg_start);
            exp_cyc.push_back(cyc + 2);
            exp_val.push_back(ex ? longint'(seg_val) * 128 : (f + 64'sd16777216) >>> 25);
            exp_exact.push_back(ex);
            exp_tag.push_back((seg_val == -8192 || seg_val == 8191) ? "R6" : "R5");
        end
    endtask

    task automatic feed(input bit v, input int x);
        @(negedge clk);
        in_valid = v;
        in_data  = (IN_W)'(x);
        if (v) model_push(x);
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) feed(1'b0, 0);
    endtask

    task automatic dc_run(input int x, input int n);
        dc_mode = 1; seg_start = nacc; seg_val = x;
        for (int i = 0; i < n; i++) feed(1'b1, x);
    endtask

    // Per-clock comparison against the model (R2, R4, R5, R6, R8).
    always @(negedge clk) begin
        if (chk_on) begin
            bit     ev;
            longint got;
            ev  = (exp_cyc.size() > 0) && (exp_cyc[0] == cyc);
            got = longint'(out_data);
            check(out_valid === ev, "R2", longint'(out_valid), longint'(ev));
            if (ev) begin
                if (exp_exact[0])
                    check(got == exp_val[0], exp_tag[0], got, exp_val[0]);
                else
                    check((got - exp_val[0] >= -1) && (got - exp_val[0] <= 1), "R4", got, exp_val[0]);
                last_out = got;
                void'(exp_cyc.pop_front()); void'(exp_val.pop_front());
                void'(exp_exact.pop_front()); void'(exp_tag.pop_front());
            end else begin
                check(got == last_out, "R8", got, last_out);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int prev;
        build_taps();
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(out_data == '0, "R1", longint'(out_data), 0);
        @(negedge clk);
        rst_n  = 1'b1;
        chk_on = 1'b1;

        dc_run(1000, 320);
        drain();
        check(last_out == 128000, "R5", last_out, 128000);

        dc_run(-8192, 320);
        drain();
        check(last_out == -1048576, "R6", last_out, -1048576);

        dc_run(8191, 320);
        drain();
        check(last_out == 1048448, "R6", last_out, 1048448);

        // R3: gaps with junk on in_data; R4 tolerance exposes any leakage.
        dc_mode = 0;
        for (int i = 0; i < 1600; i++) begin
            if ($urandom_range(3, 0) == 0) feed(1'b0, int'($urandom_range(16383, 0)) - 8192);
            else                           feed(1'b1, int'($urandom_range(16383, 0)) - 8192);
        end
        drain();

        // R4: full-scale square wave.
        for (int i = 0; i < 800; i++) feed(1'b1, ((i / 37) % 2 == 0) ? 8191 : -8192);
        drain();

        // R7: rising sweep of constant codes.
        prev = -2147483647;
        for (int c = -8192; c <= 8191 + 330; c += 331) begin
            int code;
            code = (c > 8191) ? 8191 : c;
            dc_run(code, 160);
            drain();
            check(last_out > prev, "R7", last_out, longint'(prev) + 1);
            check(last_out == longint'(code) * 128, "R7", last_out, longint'(code) * 128);
            prev = int'(last_out);
        end

        // R1: mid-run reset restarts from a clean state.
        dc_mode = 0;
        for (int i = 0; i < 100; i++) feed(1'b1, int'($urandom_range(16383, 0)) - 8192);
        drain();
        chk_on = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(out_data == '0, "R1", longint'(out_data), 0);
        xs.delete(); nacc = 0; last_out = 0;
        exp_cyc.delete(); exp_val.delete(); exp_exact.delete(); exp_tag.delete();
        rst_n  = 1'b1;
        chk_on = 1'b1;
        dc_run(-8192, 320);
        drain();
        check(last_out == -1048576, "R1", last_out, -1048576);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule